// File: doc/BRIEF.md
# Double-Precision to 32-bit Integer Converter

This block takes one packed binary64 value and turns it into a 32-bit integer. A mode input picks a signed (two's-complement) or an unsigned result. A two-bit rounding mode decides how the fraction is resolved. Values that do not fit are saturated to the bound of the chosen format. Two flags report the outcome. `invalid` marks saturation, NaN inputs, and negative values that have no unsigned representation. `inexact` marks a result that dropped nonzero fraction bits while staying valid.

A conversion starts on a one-cycle `start_i` pulse. The operand, the sign mode and the rounding mode are captured on that edge. The work then runs through a four-state sequence:

- IDLE: waits for `start_i`; the *accept* transition moves to ALIGN.
- ALIGN: classifies the operand and splits the significand into integer and remainder bits; *aligned* moves to ROUND.
- ROUND: applies the rounding increment; *rounded* moves to EMIT.
- EMIT: applies the special-case and saturation rules and loads the outputs; *emitted* returns to IDLE.

`done_o` pulses for one cycle when the outputs are updated. The result and flags then hold until the next conversion completes.

Top module: `dbl_to_int`

## Requirements
- R1: `done_o` goes high on the third rising edge after the edge that samples `start_i` high in IDLE, and it stays high for exactly one cycle. `result_o`, `invalid_o` and `inexact_o` change only together with that pulse, and they hold their values afterwards.
- R2: After reset, `done_o`, `result_o`, `invalid_o` and `inexact_o` are all 0.
- R3: `rmode_i` encodes the rounding mode as follows: 0 = nearest, 1 = toward +infinity, 2 = toward −infinity, 3 = toward zero. In nearest mode, a fraction above one half rounds the magnitude up. An exact half rounds to the even integer.
- R4: Toward +infinity raises the magnitude of a positive value with a nonzero fraction. Toward −infinity does the same for a negative value. Toward zero never raises the magnitude.
- R5: Rounding never wraps the magnitude. If the truncated magnitude is already 0xFFFFFFFF, it stays 0xFFFFFFFF.
- R6: A biased exponent of 1055 or more, infinities included, saturates and raises invalid. Unsigned mode gives 0xFFFFFFFF for positive inputs and 0 for negative ones. Signed mode gives 0x7FFFFFFF for positive inputs and 0x80000000 for negative ones.
- R7: In signed mode (`signed_i`=1), a rounded magnitude above 0x7FFFFFFF (positive) or above 0x80000000 (negative) is clamped to that bound and raises invalid. A negative value is returned as the two's complement of its magnitude.
- R8: In unsigned mode, a negative operand whose rounded magnitude is nonzero returns 0 and raises invalid. Negative zero, and negatives that round to 0, return 0 without invalid.
- R9: A nonzero operand with a biased exponent below 1022 (subnormals included) returns 0 with inexact, with two exceptions. Toward +infinity with a positive sign returns 1 with inexact. Toward −infinity with a negative sign returns 0xFFFFFFFF with inexact in signed mode, and 0 with invalid in unsigned mode.
- R10: A NaN operand returns 0 with invalid set and inexact clear.
- R11: Inexact is set exactly when fraction bits were discarded and invalid is clear. Invalid and inexact are never both set. Positive or negative zero returns 0 with both flags clear.
- R12: While a conversion is in progress, `start_i` is ignored. The operand, sign mode and rounding mode of the running conversion determine its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a conversion |
| operand_i | input | 64 | Packed binary64 operand |
| signed_i | input | 1 | 1 = signed result, 0 = unsigned result |
| rmode_i | input | 2 | Rounding mode (encoding in R3) |
| done_o | output | 1 | One-cycle pulse when new outputs are valid |
| result_o | output | 32 | Converted integer |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
Exact ties such as 2.5 and 3.5 separate ties-to-even from plain round-half-up. Values a little above and below one half separate the nearest threshold from truncation. Each directed mode is tried on both signs, which shows whether the sign/direction combination is decoded correctly. Operands at 2^31−0.5, −2^31, 2^32−0.5 and 2^32 probe the signed clamp, the unsigned clamp, the no-wrap cap and the saturation exponent. Negative values in unsigned mode, tiny values, subnormals, zeros, infinities and NaN exercise each special path. A pseudo-random sweep of exponents around the 0.5 and 2^32 edges in all modes is compared cycle by cycle against a behavioural model, and one run issues a second start while busy.

// File: rtl/dti_pkg.sv
package dti_pkg;

    localparam int DBL_W    = 64;
    localparam int EXP_W    = 11;
    localparam int MAN_W    = 52;
    localparam int INT_W    = 32;
    localparam int BIAS     = 1023;
    localparam int GUARD_W  = DBL_W - MAN_W - 1;        // zero pad below mantissa
    localparam int SH_W     = $clog2(DBL_W) + 1;        // shift amount width
    localparam int EXP_HALF = BIAS - 1;                 // exponent of 0.5
    localparam int EXP_SAT  = BIAS + INT_W;             // first saturating exponent
    localparam int SH_BASE  = BIAS + DBL_W - 1;         // shift = SH_BASE - exponent
    localparam int EXP_MAX  = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_UP      = 2'd1,
        RM_DOWN    = 2'd2,
        RM_ZERO    = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        CL_ZERO  = 3'd0,
        CL_TINY  = 3'd1,
        CL_RANGE = 3'd2,
        CL_HUGE  = 3'd3,
        CL_NAN   = 3'd4
    } class_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ALIGN = 2'd1,
        S_ROUND = 2'd2,
        S_EMIT  = 2'd3
    } state_e;

endpackage

// File: rtl/dti_unpack.sv
module dti_unpack
    import dti_pkg::*;
(
    input  logic [DBL_W-1:0] op_i,
    output class_e           cls_o,
    output logic             sign_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [MAN_W-1:0] man_o
);

    logic man_nz;

    always_comb begin
        sign_o = op_i[DBL_W-1];
        exp_o  = op_i[DBL_W-2 -: EXP_W];
        man_o  = op_i[MAN_W-1:0];
        man_nz = |man_o;

        if (exp_o == EXP_W'(EXP_MAX) && man_nz)
            cls_o = CL_NAN;
        else if (exp_o == '0 && !man_nz)
            cls_o = CL_ZERO;
        else if (exp_o >= EXP_W'(EXP_SAT))
            cls_o = CL_HUGE;
        else if (exp_o < EXP_W'(EXP_HALF))
            cls_o = CL_TINY;
        else
            cls_o = CL_RANGE;
    end

endmodule

// File: rtl/dti_align.sv
module dti_align
    import dti_pkg::*;
(
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    output logic [INT_W-1:0] int_o,
    output logic [DBL_W-1:0] rem_o
);

    localparam int DIFF_W = EXP_W + 1;
    localparam int WIDE_W = 2 * DBL_W;

    logic [DBL_W-1:0]  sig;
    logic [DIFF_W-1:0] diff;
    logic [SH_W-1:0]   shamt;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        sig   = {1'b1, man_i, {GUARD_W{1'b0}}};
        diff  = DIFF_W'(SH_BASE) - {1'b0, exp_i};
        // out-of-window exponents are clamped; the class chooses the path anyway
        shamt = (diff > DIFF_W'(DBL_W)) ? SH_W'(DBL_W) : diff[SH_W-1:0];
        wide  = {sig, {DBL_W{1'b0}}} >> shamt;
        int_o = (|wide[WIDE_W-1 -: (DBL_W-INT_W)]) ? '1 : wide[DBL_W +: INT_W];
        rem_o = wide[DBL_W-1:0];
    end

endmodule

// File: rtl/dti_round.sv
module dti_round
    import dti_pkg::*;
(
    input  logic [INT_W-1:0] int_i,
    input  logic [DBL_W-1:0] rem_i,
    input  logic             sign_i,
    input  rmode_e           rm_i,
    output logic [INT_W-1:0] mag_o,
    output logic             lost_o
);

    logic [DBL_W-1:0] incr;
    logic             carry;

    always_comb begin
        unique case (rm_i)
            RM_NEAREST: incr = int_i[0] ? {1'b1, {(DBL_W-1){1'b0}}}
                                        : {1'b0, {(DBL_W-1){1'b1}}};
            RM_UP:      incr = sign_i ? '0 : '1;
            RM_DOWN:    incr = sign_i ? '1 : '0;
            default:    incr = '0;
        endcase
        // rem + incr overflows exactly when rem exceeds the complement of incr
        carry  = rem_i > ~incr;
        mag_o  = (carry && int_i != '1) ? int_i + 1'b1 : int_i;
        lost_o = |rem_i;
    end

endmodule

// File: rtl/dti_finish.sv
module dti_finish
    import dti_pkg::*;
(
    input  class_e           cls_i,
    input  logic             sign_i,
    input  logic             signed_i,
    input  rmode_e           rm_i,
    input  logic [INT_W-1:0] mag_i,
    input  logic             lost_i,
    output logic [INT_W-1:0] result_o,
    output logic             invalid_o,
    output logic             inexact_o
);

    localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

    logic [INT_W-1:0] bound;
    logic [INT_W-1:0] clip;

    always_comb begin
        result_o  = '0;
        invalid_o = 1'b0;
        inexact_o = 1'b0;
        bound     = sign_i ? SMIN : SMAX;
        clip      = mag_i;

        unique case (cls_i)
            CL_ZERO: begin
                result_o = '0;
            end
            CL_NAN: begin
                invalid_o = 1'b1;
            end
            CL_HUGE: begin
                invalid_o = 1'b1;
                if (signed_i)
                    result_o = bound;
                else
                    result_o = sign_i ? '0 : '1;
            end
            CL_TINY: begin
                if (rm_i == RM_UP && !sign_i) begin
                    result_o  = INT_W'(1);
                    inexact_o = 1'b1;
                end else if (rm_i == RM_DOWN && sign_i) begin
                    if (signed_i) begin
                        result_o  = '1;
                        inexact_o = 1'b1;
                    end else begin
                        invalid_o = 1'b1;
                    end
                end else begin
                    inexact_o = 1'b1;
                end
            end
            CL_RANGE: begin
                if (!signed_i) begin
                    if (sign_i && mag_i != '0) begin
                        invalid_o = 1'b1;
                    end else begin
                        result_o  = mag_i;
                        inexact_o = lost_i;
                    end
                end else begin
                    if (mag_i > bound) begin
                        clip      = bound;
                        invalid_o = 1'b1;
                    end else begin
                        inexact_o = lost_i;
                    end
                    result_o = sign_i ? (~clip + 1'b1) : clip;
                end
            end
            default: begin
                invalid_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dbl_to_int.sv
module dbl_to_int
    import dti_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] operand_i,
    input  logic        signed_i,
    input  logic [1:0]  rmode_i,
    output logic        done_o,
    output logic [31:0] result_o,
    output logic        invalid_o,
    output logic        inexact_o
);

    state_e state, state_nx;

    logic [DBL_W-1:0] cap_op;
    logic             cap_signed;
    rmode_e           cap_rm;

    class_e           cls_w, cls_q;
    logic             sign_w;
    logic [EXP_W-1:0] exp_w;
    logic [MAN_W-1:0] man_w;
    logic [INT_W-1:0] int_w, int_q;
    logic [DBL_W-1:0] rem_w, rem_q;
    logic [INT_W-1:0] mag_w, mag_q;
    logic             lost_w, lost_q;
    logic [INT_W-1:0] fin_result;
    logic             fin_invalid, fin_inexact;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start_i) state_nx = S_ALIGN;   // accept
            S_ALIGN: state_nx = S_ROUND;                // aligned
            S_ROUND: state_nx = S_EMIT;                 // rounded
            S_EMIT:  state_nx = S_IDLE;                 // emitted
            default: state_nx = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // ---------------- datapath stages ----------------
    dti_unpack u_unpack (
        .op_i   (cap_op),
        .cls_o  (cls_w),
        .sign_o (sign_w),
        .exp_o  (exp_w),
        .man_o  (man_w)
    );

    dti_align u_align (
        .exp_i (exp_w),
        .man_i (man_w),
        .int_o (int_w),
        .rem_o (rem_w)
    );

    dti_round u_round (
        .int_i  (int_q),
        .rem_i  (rem_q),
        .sign_i (sign_w),
        .rm_i   (cap_rm),
        .mag_o  (mag_w),
        .lost_o (lost_w)
    );

    dti_finish u_finish (
        .cls_i     (cls_q),
        .sign_i    (sign_w),
        .signed_i  (cap_signed),
        .rm_i      (cap_rm),
        .mag_i     (mag_q),
        .lost_i    (lost_q),
        .result_o  (fin_result),
        .invalid_o (fin_invalid),
        .inexact_o (fin_inexact)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_op     <= '0;
            cap_signed <= 1'b0;
            cap_rm     <= RM_NEAREST;
            cls_q      <= CL_ZERO;
            int_q      <= '0;
            rem_q      <= '0;
            mag_q      <= '0;
            lost_q     <= 1'b0;
        end else begin
            if (state == S_IDLE && start_i) begin
                cap_op     <= operand_i;
                cap_signed <= signed_i;
                cap_rm     <= rmode_e'(rmode_i);
            end
            if (state == S_ALIGN) begin
                cls_q <= cls_w;
                int_q <= int_w;
                rem_q <= rem_w;
            end
            if (state == S_ROUND) begin
                mag_q  <= mag_w;
                lost_q <= lost_w;
            end
        end
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            result_o  <= '0;
            invalid_o <= 1'b0;
            inexact_o <= 1'b0;
        end else begin
            done_o <= (state == S_EMIT);
            if (state == S_EMIT) begin
                result_o  <= fin_result;
                invalid_o <= fin_invalid;
                inexact_o <= fin_inexact;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state, 3) == S_ALIGN));

    assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(cap_op) && $stable(cap_signed) && $stable(cap_rm)));

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(invalid_o && inexact_o));

    assert_signed_positive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_signed && !cap_op[DBL_W-1]) |-> !result_o[INT_W-1]);

    assert_unsigned_negative_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cap_signed && cap_op[DBL_W-1]) |-> (result_o == '0));

endmodule

// File: tb/dbl_to_int_bench.sv
module dbl_to_int_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic        signed_i = 1'b0;
    logic [1:0]  rmode_i = 2'd0;
    logic        done_o;
    logic [31:0] result_o;
    logic        invalid_o;
    logic        inexact_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    dbl_to_int u_dbl_to_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .operand_i (operand_i),
        .signed_i  (signed_i),
        .rmode_i   (rmode_i),
        .done_o    (done_o),
        .result_o  (result_o),
        .invalid_o (invalid_o),
        .inexact_o (inexact_o)
    );

    // Behavioural model from the requirements: returns {result, invalid, inexact}
    function automatic logic [33:0] ref_conv(input logic [63:0] op, input bit sg,
                                             input logic [1:0] rm);
        bit s = op[63];
        int e = int'(op[62:52]);
        longint unsigned m = 64'(op[51:0]);
        longint unsigned big, ip, fr, half, lim;
        int sh;
        bit up;
        logic [31:0] r = '0;
        bit inv = 0, inx = 0;
        if (e == 2047 && m != 0) begin            // R10
            inv = 1;
        end else if (e == 0 && m == 0) begin      // R11 zero
            r = '0;
        end else if (e >= 1055) begin             // R6
            inv = 1;
            r = sg ? (s ? 32'h8000_0000 : 32'h7FFF_FFFF) : (s ? 32'h0 : 32'hFFFF_FFFF);
        end else if (e < 1022) begin              // R9
            if (rm == 2'd1 && !s) begin r = 32'd1; inx = 1; end
            else if (rm == 2'd2 && s) begin
                if (sg) begin r = 32'hFFFF_FFFF; inx = 1; end
                else inv = 1;
            end else inx = 1;
        end else begin
            big  = m | (64'd1 << 52);
            sh   = 1075 - e;
            ip   = big >> sh;
            fr   = big & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
            case (rm)
                2'd0:    up = (fr > half) || (fr == half && ip[0]);   // R3
                2'd1:    up = (fr != 0) && !s;                        // R4
                2'd2:    up = (fr != 0) && s;
                default: up = 0;
            endcase
            if (up && ip != 64'hFFFF_FFFF) ip = ip + 64'd1;           // R5
            inx = (fr != 0);
            if (!sg) begin                                            // R8
                if (s && ip != 0) begin inv = 1; inx = 0; r = '0; end
                else r = ip[31:0];
            end else begin                                            // R7
                lim = s ? 64'h8000_0000 : 64'h7FFF_FFFF;
                if (ip > lim) begin ip = lim; inv = 1; inx = 0; end
                r = s ? 32'(64'd0 - ip) : ip[31:0];
            end
        end
        return {r, inv, inx};
    endfunction

    task automatic check_done(input bit exp_done, input string tag);
        n_checks++;
        if (done_o !== exp_done) begin
            n_fail++;
            $display("FAIL %s done_o actual=%0b expected=%0b", tag, done_o, exp_done);
        end
    endtask

    task automatic check_out(input logic [33:0] exp_v, input string tag);
        n_checks++;
        if ({result_o, invalid_o, inexact_o} !== exp_v) begin
            n_fail++;
            $display("FAIL %s result/inv/inx actual=%h/%0b/%0b expected=%h/%0b/%0b",
                     tag, result_o, invalid_o, inexact_o, exp_v[33:2], exp_v[1], exp_v[0]);
        end
    endtask

    // One conversion, compared on each of the following clocks (R1);
    // with overlap, a second start with different inputs is issued while busy (R12)
    task automatic run_conv(input logic [63:0] op, input bit sg, input logic [1:0] rm,
                            input string tag, input bit overlap);
        logic [33:0] exp_v = ref_conv(op, sg, rm);
        @(negedge clk);
        operand_i = op;
        signed_i  = sg;
        rmode_i   = rm;
        start_i   = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (overlap) begin
                    operand_i = ~op;
                    signed_i  = ~sg;
                    rmode_i   = rm + 2'd1;
                end else begin
                    start_i = 1'b0;
                end
            end else if (k == 2) begin
                start_i = 1'b0;
            end
            if (k < 4) check_done(1'b0, overlap ? "R12" : "R1");
            else begin
                check_done(1'b1, "R1");
                check_out(exp_v, tag);
            end
        end
        @(negedge clk);
        check_done(1'b0, "R1");
        check_out(exp_v, "R1 hold");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        n_checks++;
        if (done_o !== 1'b0 || result_o !== 32'h0 || invalid_o !== 1'b0 || inexact_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset actual=%0b/%h/%0b/%0b expected=0/00000000/0/0",
                     done_o, result_o, invalid_o, inexact_o);
        end
        rst_n = 1'b1;

        // R3 nearest: ties to even and off-half fractions
        run_conv(64'h4004_0000_0000_0000, 1'b1, 2'd0, "R3 2.5", 1'b0);
        run_conv(64'h400C_0000_0000_0000, 1'b1, 2'd0, "R3 3.5", 1'b0);
        run_conv(64'h3FE8_0000_0000_0000, 1'b0, 2'd0, "R3 0.75", 1'b0);
        run_conv(64'h3FE0_0000_0000_0000, 1'b0, 2'd0, "R3 0.5", 1'b0);
        run_conv(64'hBFF8_0000_0000_0000, 1'b1, 2'd0, "R3 -1.5", 1'b0);
        // R4 directed modes on both signs
        run_conv(64'h3FF8_0000_0000_0000, 1'b1, 2'd1, "R4 1.5 up", 1'b0);
        run_conv(64'hBFF8_0000_0000_0000, 1'b1, 2'd1, "R4 -1.5 up", 1'b0);
        run_conv(64'hBFF8_0000_0000_0000, 1'b1, 2'd2, "R4 -1.5 down", 1'b0);
        run_conv(64'h3FF8_0000_0000_0000, 1'b1, 2'd3, "R4 1.5 zero", 1'b0);
        run_conv(64'hBFE0_0000_0000_0000, 1'b1, 2'd2, "R4 -0.5 down", 1'b0);
        // R5 no wrap at all-ones
        run_conv(64'h41EF_FFFF_FFF0_0000, 1'b0, 2'd1, "R5 2^32-0.5 up", 1'b0);
        run_conv(64'h41EF_FFFF_FFF0_0000, 1'b0, 2'd0, "R5 2^32-0.5 nearest", 1'b0);
        // R6 saturation
        run_conv(64'h41F0_0000_0000_0000, 1'b0, 2'd0, "R6 2^32 unsigned", 1'b0);
        run_conv(64'h7FF0_0000_0000_0000, 1'b1, 2'd0, "R6 +inf signed", 1'b0);
        run_conv(64'hFFF0_0000_0000_0000, 1'b1, 2'd3, "R6 -inf signed", 1'b0);
        run_conv(64'hC1F0_0000_0000_0000, 1'b0, 2'd0, "R6 -2^32 unsigned", 1'b0);
        // R7 signed clamp and negation
        run_conv(64'h41E0_0000_0000_0000, 1'b1, 2'd0, "R7 2^31", 1'b0);
        run_conv(64'hC1E0_0000_0000_0000, 1'b1, 2'd0, "R7 -2^31", 1'b0);
        run_conv(64'h41DF_FFFF_FFE0_0000, 1'b1, 2'd0, "R7 2^31-0.5 signed", 1'b0);
        run_conv(64'h41DF_FFFF_FFE0_0000, 1'b0, 2'd0, "R7 2^31-0.5 unsigned", 1'b0);
        run_conv(64'hC1E0_0000_0020_0000, 1'b1, 2'd2, "R7 below -2^31", 1'b0);
        // R8 unsigned negatives
        run_conv(64'hBFF0_0000_0000_0000, 1'b0, 2'd3, "R8 -1.0", 1'b0);
        run_conv(64'hBFE8_0000_0000_0000, 1'b0, 2'd0, "R8 -0.75 nearest", 1'b0);
        run_conv(64'hBFE8_0000_0000_0000, 1'b0, 2'd3, "R8 -0.75 zero", 1'b0);
        run_conv(64'h8000_0000_0000_0000, 1'b0, 2'd0, "R8 -0", 1'b0);
        // R9 tiny magnitudes
        run_conv(64'h3FD0_0000_0000_0000, 1'b1, 2'd1, "R9 0.25 up", 1'b0);
        run_conv(64'hBFD0_0000_0000_0000, 1'b1, 2'd2, "R9 -0.25 down signed", 1'b0);
        run_conv(64'hBFD0_0000_0000_0000, 1'b0, 2'd2, "R9 -0.25 down unsigned", 1'b0);
        run_conv(64'h0000_0000_0000_0001, 1'b1, 2'd0, "R9 subnormal", 1'b0);
        run_conv(64'h0000_0000_0000_0001, 1'b0, 2'd1, "R9 subnormal up", 1'b0);
        // R10 NaN
        run_conv(64'h7FF8_0000_0000_0000, 1'b1, 2'd0, "R10 qNaN", 1'b0);
        run_conv(64'hFFF0_0000_0000_0001, 1'b0, 2'd1, "R10 sNaN", 1'b0);
        // R11 zero and exact values
        run_conv(64'h0000_0000_0000_0000, 1'b1, 2'd1, "R11 +0", 1'b0);
        run_conv(64'h3FF0_0000_0000_0000, 1'b0, 2'd1, "R11 1.0 exact", 1'b0);
        // R12 start while busy
        run_conv(64'h4004_0000_0000_0000, 1'b1, 2'd0, "R12 busy start", 1'b1);

        // sweep around the range edges in every mode (R3 R4 R7 R8 R9 R11)
        for (int i = 0; i < 400; i++) begin
            logic [63:0] rnd = {$urandom(), $urandom()};
            logic [10:0] ex = 11'(1015 + ($urandom() % 45));
            run_conv({rnd[63], ex, rnd[51:0]}, rnd[62], rnd[61:60], "R4 sweep", 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule